// File: doc/BRIEF.md
# Eight-Bit Dual-Compare Timer

This block is an up-counting timer with two compare channels. It sits on a small register bus. A free-running counter advances on every cycle in which the tick enable input is high. On such a tick, each channel compares its own compare value with the counter. When they are equal, the channel sets a pending flag and toggles its waveform output. When the counter wraps from its top value back to zero, a third flag is set.

Software can read and write the counter, both compare values and a three-bit interrupt mask. The pending flags are cleared by writing ones to a flag register. Each interrupt request line is high only when three things hold together: its flag is pending, its mask bit is set, and the global enable input is high.

A bus write to the counter blocks compare matching on the next tick that follows it. A value just loaded into the counter therefore does not fire a compare at once. The overflow flag is not affected by this blocking.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both compare values, the mask, both flags sets and both waveform outputs are zero, and every address reads zero.
- R2: The counter (address 0) increases by one on each cycle with `tickEn` high and holds its value on every other cycle.
- R3: On a tick with the counter at 255, the counter becomes 0 and flag bit 0 (overflow) is set.
- R4: A bus write loads the counter (address 0), compare A (address 1), compare B (address 2) or the mask (address 3). All four read back the written value, and a counter write wins over a tick in the same cycle.
- R5: The mask register holds channel-B enable in bit 2, channel-A enable in bit 1 and overflow enable in bit 0. Bits 7 to 3 always read zero, whatever is written to them.
- R6: On a tick that is not blocked and has the counter equal to compare A (or B), flag bit 1 (or bit 2) is set and `waveA` (or `waveB`) toggles.
- R7: After a counter write, the first tick that follows produces no compare match, even if idle cycles come between the write and that tick. The tick after it compares normally.
- R8: Each of `irqOvf`, `irqCmpA` and `irqCmpB` is high exactly when its flag bit is set, its mask bit is set and `globalIrqEn` is high.
- R9: The flag register at address 4 uses the same bit layout as the mask. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set event and a clear happen in the same cycle, the set event wins.
- R10: Addresses 5 to 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Timer tick enable; the counter advances in cycles where it is high |
| globalIrqEn | input | 1 | Global interrupt enable |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| waveA | output | 1 | Channel A waveform output, toggles on a match |
| waveB | output | 1 | Channel B waveform output, toggles on a match |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmpA | output | 1 | Compare A interrupt request |
| irqCmpB | output | 1 | Compare B interrupt request |

## Verification
The first pattern is a steady run of ticks from zero with distinct compare values. It shows whether matches fire on the right count, and whether channel A is kept apart from channel B. Counter writes are then placed one tick before the compare value and right on it, with and without idle cycles in between. This shows whether blocking covers exactly the next tick. Runs that cross 255, and a flag clear in the same cycle as a set event, separate the correct wrap handling and set-over-clear priority from variants that get them wrong. A long phase of gappy ticks with random bus writes then checks every output against the reference model on every cycle.

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;
  // bit positions shared by the mask and flag registers
  localparam int unsigned OVF_BIT  = 0;
  localparam int unsigned CMPA_BIT = 1;
  localparam int unsigned CMPB_BIT = 2;
  localparam int unsigned IRQ_N    = 3;

  typedef struct packed {
    logic tick;
    logic loadCnt;
    logic loadCmpA;
    logic loadCmpB;
    logic blockMatch;
  } dpStrobe_t;
endpackage

// File: rtl/dctimer_datapath.sv
module dctimer_datapath
  import dctimer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strobe,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmpA,
  output logic [W-1:0] cmpB,
  output logic         matchA,
  output logic         matchB,
  output logic         wrapEv,
  output logic         waveA,
  output logic         waveB
);
  localparam int unsigned CH_N = 2;
  localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

  logic [W-1:0] cntQ;
  logic [CH_N-1:0][W-1:0] cmpQ;
  logic [CH_N-1:0] matchEv;
  logic [CH_N-1:0] waveQ;
  logic [CH_N-1:0] loadCh;
  logic advance;

  assign advance = strobe.tick && !strobe.loadCnt;
  assign loadCh  = {strobe.loadCmpB, strobe.loadCmpA};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.loadCnt) cntQ <= wrData;
    else if (strobe.tick)    cntQ <= cntQ + 1'b1;
  end

  assign wrapEv = advance && (cntQ == CNT_TOP);

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cmpQ[ch] <= '0;
      else if (loadCh[ch]) cmpQ[ch] <= wrData;
    end

    assign matchEv[ch] = advance && !strobe.blockMatch && (cntQ == cmpQ[ch]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           waveQ[ch] <= 1'b0;
      else if (matchEv[ch]) waveQ[ch] <= ~waveQ[ch];
    end

    // R6
    wave_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
      matchEv[ch] |=> (waveQ[ch] != $past(waveQ[ch])));
  end

  assign cnt    = cntQ;
  assign cmpA   = cmpQ[0];
  assign cmpB   = cmpQ[1];
  assign matchA = matchEv[0];
  assign matchB = matchEv[1];
  assign waveA  = waveQ[0];
  assign waveB  = waveQ[1];

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> (cntQ == $past(cntQ) + 1'b1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.loadCnt) |=> $stable(cntQ));
  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && cntQ == CNT_TOP) |=> (cntQ == '0));
  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (cntQ == $past(wrData)));
endmodule

// File: rtl/dctimer_ctrl.sv
module dctimer_ctrl
  import dctimer_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          globalIrqEn,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [W-1:0]  busWrData,
  input  logic [W-1:0]  cnt,
  input  logic [W-1:0]  cmpA,
  input  logic [W-1:0]  cmpB,
  input  logic          matchA,
  input  logic          matchB,
  input  logic          wrapEv,
  output dpStrobe_t     strobe,
  output logic [W-1:0]  busRdData,
  output logic [IRQ_N-1:0] irqVec
);
  localparam logic [AW-1:0] ADDR_CNT  = AW'(0);
  localparam logic [AW-1:0] ADDR_CMPA = AW'(1);
  localparam logic [AW-1:0] ADDR_CMPB = AW'(2);
  localparam logic [AW-1:0] ADDR_MASK = AW'(3);
  localparam logic [AW-1:0] ADDR_FLAG = AW'(4);
  localparam int unsigned PAD_W = W - IRQ_N;

  logic [IRQ_N-1:0] maskQ;
  logic [IRQ_N-1:0] flagQ;
  logic [IRQ_N-1:0] setVec;
  logic [IRQ_N-1:0] clrVec;
  logic blockPend;
  logic wrCnt, wrMask, wrFlag;

  assign wrCnt  = busWrEn && (busAddr == ADDR_CNT);
  assign wrMask = busWrEn && (busAddr == ADDR_MASK);
  assign wrFlag = busWrEn && (busAddr == ADDR_FLAG);

  always_comb begin
    strobe.tick       = tickEn;
    strobe.loadCnt    = wrCnt;
    strobe.loadCmpA   = busWrEn && (busAddr == ADDR_CMPA);
    strobe.loadCmpB   = busWrEn && (busAddr == ADDR_CMPB);
    strobe.blockMatch = blockPend;
  end

  // a counter write arms the block; the next tick consumes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       blockPend <= 1'b0;
    else if (wrCnt)  blockPend <= 1'b1;
    else if (tickEn) blockPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       maskQ <= '0;
    else if (wrMask) maskQ <= busWrData[IRQ_N-1:0];
  end

  always_comb begin
    setVec = '0;
    setVec[OVF_BIT]  = wrapEv;
    setVec[CMPA_BIT] = matchA;
    setVec[CMPB_BIT] = matchB;
    clrVec = wrFlag ? busWrData[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrVec) | setVec;
  end

  assign irqVec = flagQ & maskQ & {IRQ_N{globalIrqEn}};

  always_comb begin
    case (busAddr)
      ADDR_CNT:  busRdData = cnt;
      ADDR_CMPA: busRdData = cmpA;
      ADDR_CMPB: busRdData = cmpB;
      ADDR_MASK: busRdData = {{PAD_W{1'b0}}, maskQ};
      ADDR_FLAG: busRdData = {{PAD_W{1'b0}}, flagQ};
      default:   busRdData = '0;
    endcase
  end

  // R5
  always_comb begin
    if (rstN && busAddr == ADDR_MASK)
      mask_pad_chk: assert (busRdData[W-1:IRQ_N] == '0);
  end
  // R7
  block_cmpa_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockPend && tickEn && !flagQ[CMPA_BIT]) |=> !flagQ[CMPA_BIT]);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchA && wrFlag) |=> flagQ[CMPA_BIT]);
  // R8
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalIrqEn |-> (irqVec == '0));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dctimer_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          globalIrqEn,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [W-1:0]  busWrData,
  output logic [W-1:0]  busRdData,
  output logic          waveA,
  output logic          waveB,
  output logic          irqOvf,
  output logic          irqCmpA,
  output logic          irqCmpB
);
  dpStrobe_t strobe;
  logic [W-1:0] cnt, cmpA, cmpB;
  logic matchA, matchB, wrapEv;
  logic [IRQ_N-1:0] irqVec;

  dctimer_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .globalIrqEn(globalIrqEn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB),
    .matchA(matchA), .matchB(matchB), .wrapEv(wrapEv),
    .strobe(strobe), .busRdData(busRdData), .irqVec(irqVec)
  );

  dctimer_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB),
    .matchA(matchA), .matchB(matchB), .wrapEv(wrapEv),
    .waveA(waveA), .waveB(waveB)
  );

  assign irqOvf  = irqVec[OVF_BIT];
  assign irqCmpA = irqVec[CMPA_BIT];
  assign irqCmpB = irqVec[CMPB_BIT];
endmodule

// File: tb/dual_cmp_timer_bench.sv
`timescale 1ns/1ps
module dual_cmp_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic globalIrqEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic waveA, waveB, irqOvf, irqCmpA, irqCmpB;

  always #2 clk = ~clk;

  dual_cmp_timer u_dual_cmp_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .globalIrqEn(globalIrqEn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .waveA(waveA), .waveB(waveB),
    .irqOvf(irqOvf), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  int mCnt, mA, mB, mMask, mFlag, mWA, mWB, mBlk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mA = 0; mB = 0; mMask = 0; mFlag = 0; mWA = 0; mWB = 0; mBlk = 0;
    end else begin
      int wd;
      bit wrC, eA, eB, eO;
      wd  = int'(busWrData);
      wrC = busWrEn && busAddr == 3'd0;
      eA = 0; eB = 0; eO = 0;
      if (tickEn && !wrC) begin
        if (mBlk == 0 && mCnt == mA) eA = 1;
        if (mBlk == 0 && mCnt == mB) eB = 1;
        if (mCnt == 255) eO = 1;
      end
      if (busWrEn && busAddr == 3'd4) mFlag = mFlag & ~(wd & 7);
      if (eO) mFlag = mFlag | 1;
      if (eA) begin mFlag = mFlag | 2; mWA = 1 - mWA; end
      if (eB) begin mFlag = mFlag | 4; mWB = 1 - mWB; end
      if (wrC) mBlk = 1;
      else if (tickEn) mBlk = 0;
      if (wrC) mCnt = wd;
      else if (tickEn) mCnt = (mCnt + 1) % 256;
      if (busWrEn && busAddr == 3'd1) mA = wd;
      if (busWrEn && busAddr == 3'd2) mB = wd;
      if (busWrEn && busAddr == 3'd3) mMask = wd & 7;
    end
  end

  function automatic int expRd(input int a);
    case (a)
      0: return mCnt;
      1: return mA;
      2: return mB;
      3: return mMask;
      4: return mFlag;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chkAll();
    string rq;
    int g;
    g = globalIrqEn ? 1 : 0;
    case (busAddr)
      3'd0: rq = "R2";
      3'd1, 3'd2: rq = "R4";
      3'd3: rq = "R5";
      3'd4: rq = "R9";
      default: rq = "R10";
    endcase
    chk(rq, "busRdData", int'(busRdData), expRd(int'(busAddr)));
    chk("R6", "waveA", int'(waveA), mWA);
    chk("R6", "waveB", int'(waveB), mWB);
    chk("R8", "irqOvf", int'(irqOvf), (mFlag & mMask & 1) != 0 && g == 1 ? 1 : 0);
    chk("R8", "irqCmpA", int'(irqCmpA), (mFlag & mMask & 2) != 0 && g == 1 ? 1 : 0);
    chk("R8", "irqCmpB", int'(irqCmpB), (mFlag & mMask & 4) != 0 && g == 1 ? 1 : 0);
  endtask

  // one cycle: drive at the falling edge, compare at the next falling edge
  task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    tickEn = t; busWrEn = w; busAddr = a; busWrData = d;
    @(negedge clk);
    chkAll();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic peek(input logic [2:0] a);
    cyc(1'b0, 1'b0, a, 8'h00);
  endtask

  initial begin
    int w0;
    @(negedge clk);
    // R1: every register reads zero while held in reset
    for (int a = 0; a < 8; a++) begin
      peek(3'(a));
      chk("R1", "reset read", int'(busRdData), 0);
    end
    chk("R1", "reset waves", int'(waveA) + int'(waveB), 0);
    rstN = 1'b1;
    globalIrqEn = 1'b1;

    wr(3'd1, 8'd5);
    wr(3'd2, 8'd10);
    wr(3'd3, 8'hFF);
    peek(3'd3);
    chk("R5", "mask upper bits", int'(busRdData), 7);
    peek(3'd1);
    chk("R4", "cmpA readback", int'(busRdData), 5);

    // R6: steady ticks from zero, matches at 5 and 10
    ticks(12, 3'd0);
    peek(3'd4);
    chk("R6", "flags after run", int'(busRdData), 6);
    chk("R6", "waves toggled", int'(waveA) + int'(waveB), 2);

    // R9: clear all flags
    wr(3'd4, 8'h07);
    peek(3'd4);
    chk("R9", "flags cleared", int'(busRdData), 0);

    // R7: write the compare value itself; the next tick must not match
    w0 = int'(waveA);
    wr(3'd0, 8'd5);
    ticks(1, 3'd4);
    chk("R7", "no flag after write at cmp", int'(busRdData), 0);
    chk("R7", "waveA held", int'(waveA), w0);
    // R7: one below compare; blocked tick then a normal match
    wr(3'd0, 8'd4);
    ticks(1, 3'd4);
    chk("R7", "blocked tick", int'(busRdData), 0);
    wr(3'd0, 8'd5);
    peek(3'd0);
    peek(3'd0);
    ticks(1, 3'd4);
    chk("R7", "block survives idle cycles", int'(busRdData), 0);
    wr(3'd0, 8'd4);
    ticks(2, 3'd4);
    chk("R7", "match after block", int'(busRdData), 2);
    // R4: counter write wins over a tick in the same cycle
    cyc(1'b1, 1'b1, 3'd0, 8'd77);
    chk("R4", "write beats tick", int'(busRdData), 77);
    wr(3'd4, 8'h07);

    // R3: wrap past 255
    wr(3'd0, 8'd250);
    ticks(10, 3'd0);
    chk("R3", "count after wrap", int'(busRdData), 4);
    peek(3'd4);
    chk("R3", "overflow flag", int'(busRdData) & 1, 1);
    wr(3'd4, 8'h07);

    // R9: set and clear of flag A in the same cycle
    wr(3'd0, 8'd3);
    ticks(1, 3'd0);
    ticks(1, 3'd0);
    cyc(1'b1, 1'b1, 3'd4, 8'h02);
    peek(3'd4);
    chk("R9", "set beats clear", int'(busRdData) & 2, 2);
    chk("R8", "irqCmpA high", int'(irqCmpA), 1);

    // R8: gating by global enable and by mask
    globalIrqEn = 1'b0;
    peek(3'd4);
    chk("R8", "gie off", int'(irqCmpA), 0);
    globalIrqEn = 1'b1;
    wr(3'd3, 8'h05);
    chk("R8", "mask A off", int'(irqCmpA), 0);

    // R10: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      chk("R10", "unmapped read", int'(busRdData), 0);
    end
    peek(3'd1);
    chk("R10", "cmpA untouched", int'(busRdData), 5);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic t, w;
      logic [2:0] a;
      t = ($urandom % 4) != 0;
      w = ($urandom % 8) == 0;
      a = 3'($urandom % 8);
      if (($urandom % 16) == 0) globalIrqEn = ~globalIrqEn;
      cyc(t, w, a, 8'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule